// File: doc/BRIEF.md
# Reset and Clock-Ready Sequencer

This block is the reset controller of a small processor. It holds the system reset output high until supply power is stable and the selected clock source can be used. Two supply detectors feed it as level inputs: a power-on detector and a brown-out detector. A vector of warm-reset request lines and a software reset strobe complete the set of reset sources. The analog detectors, the oscillators and the PLL are outside the block. Their timing reaches it as two pulse inputs: a reference tick, which times the programmable waits, and an oscillator tick, which gives one pulse per oscillator clock period.

A cold reset comes from either supply detector. It runs the whole chain: supply hold, power-up timer, then the oscillator stages. During the supply hold the active oscillator selection is reloaded from the configuration code. A warm reset comes from any other source. It keeps the running oscillator selection and runs only the oscillator stages. Which oscillator stages run depends on a 3-bit mode code. On release the block starts a fetch at the reset vector with a one-cycle strobe, enables the clock monitor, and records the cause of the last reset on a 2-bit output.

Top module: `rsq_top`

## Requirements
- R1: While `por_low` is high, the sequence stays in its first stage and `sys_rst` is high from the next cycle on. `rst_cause` reads 2'b01 (power-on), and power-on takes precedence when both detectors are high.
- R2: While `bor_low` is high and `por_low` is low, the sequence holds in the brown-out stage with `sys_rst` high. `rst_cause` reads 2'b10.
- R3: On a cold reset, `active_osc` is loaded from `cfg_osc_mode` during the hold stages. Codes 4 and 6 are unused and become 0. The mode codes are: 0 fast RC, 1 fast RC with PLL, 2 primary oscillator, 3 primary with PLL, 5 low-power RC, 7 fast RC divided.
- R4: A warm reset (any `warm_req` bit or `sw_reset`) leaves `active_osc` unchanged and sets `rst_cause` to 2'b11.
- R5: Once both detectors are low, the power-up timer waits PWRT_TICKS reference ticks. `osc_en` stays low until that timer expires.
- R6: The oscillator stages depend on the active mode. The start-up delay of OSCD_TICKS ticks always runs. The start-up timer of OST_CYCLES (1024) oscillator ticks runs for modes 2 and 3. The lock wait of LOCK_TICKS ticks runs for modes 1 and 3. With both ticks high every cycle, `sys_rst` falls 1+PWRT+OSCD+ost+lock clock edges after the last edge on which a detector was high.
- R7: A warm reset starts at the oscillator start-up delay. `sys_rst` falls 1+OSCD+ost+lock edges after the last edge on which a request was seen.
- R8: A warm request during the supply-hold or power-up timer stages has no effect on timing or cause. During an oscillator stage, or after release, it restarts the sequence from the start-up delay.
- R9: On release, `boot_fetch` is high for exactly one cycle with `fetch_addr` equal to 0, and `clkmon_en` is high only while `sys_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous flop initialisation, active low |
| por_low | input | 1 | Power-on detector: supply below threshold |
| bor_low | input | 1 | Brown-out detector: supply below threshold |
| warm_req | input | NWARM | Warm reset request lines |
| sw_reset | input | 1 | Software reset instruction strobe |
| ref_tick | input | 1 | Reference tick for programmable waits |
| osc_tick | input | 1 | One pulse per oscillator clock period |
| cfg_osc_mode | input | 3 | Configured oscillator mode code |
| sys_rst | output | 1 | System reset, active high |
| osc_en | output | 1 | Oscillator enable |
| clkmon_en | output | 1 | Clock monitor enable |
| boot_fetch | output | 1 | One-cycle fetch-start strobe at release |
| fetch_addr | output | AW | Fetch address during the strobe |
| active_osc | output | 3 | Oscillator mode currently in use |
| rst_cause | output | 2 | Cause of the last reset |

## Verification
The hardest case to reach from the ports is a warm request that lands inside the 1024-cycle oscillator start-up timer. It has to restart the sequence rather than extend it. The bench reaches this case by first releasing in the primary-oscillator mode. It then issues one warm request, counts edges until the sequence is well inside the timer stage, and issues a second one. Only the second request may set the release time. A request placed inside the power-up timer of a cold sequence checks the opposite case: the release edge and the cause must not move.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_BOR  = 3'd1,
    ST_PWRT = 3'd2,
    ST_OSCD = 3'd3,
    ST_OST  = 3'd4,
    ST_LOCK = 3'd5,
    ST_RUN  = 3'd6
  } stage_t;

  localparam logic [1:0] CAUSE_POR  = 2'b01;
  localparam logic [1:0] CAUSE_BOR  = 2'b10;
  localparam logic [1:0] CAUSE_WARM = 2'b11;

  function automatic logic [2:0] osc_normalize(input logic [2:0] code);
    return (code == 3'd4 || code == 3'd6) ? 3'd0 : code;
  endfunction

  function automatic logic osc_has_ost(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic logic osc_has_pll(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd3);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsq_mode_decode.sv
module rsq_mode_decode
  import rsq_pkg::*;
(
  input  logic [2:0] code,
  output logic [2:0] norm,
  output logic       need_ost,
  output logic       need_pll
);
  assign norm     = osc_normalize(code);
  assign need_ost = osc_has_ost(code);
  assign need_pll = osc_has_pll(code);
endmodule

// File: rtl/rsq_delay_timer.sv
module rsq_delay_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/rsq_top.sv
module rsq_top
  import rsq_pkg::*;
#(
  parameter int NWARM      = 3,
  parameter int AW         = 24,
  parameter logic [AW-1:0] RESET_VEC = '0,
  parameter int PWRT_TICKS = 2048,
  parameter int OSCD_TICKS = 16,
  parameter int OST_CYCLES = 1024,
  parameter int LOCK_TICKS = 1500
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             por_low,
  input  logic             bor_low,
  input  logic [NWARM-1:0] warm_req,
  input  logic             sw_reset,
  input  logic             ref_tick,
  input  logic             osc_tick,
  input  logic [2:0]       cfg_osc_mode,
  output logic             sys_rst,
  output logic             osc_en,
  output logic             clkmon_en,
  output logic             boot_fetch,
  output logic [AW-1:0]    fetch_addr,
  output logic [2:0]       active_osc,
  output logic [1:0]       rst_cause
);
  localparam int MAXL = max2(max2(PWRT_TICKS, OSCD_TICKS), max2(OST_CYCLES, LOCK_TICKS));
  localparam int CW   = $clog2(MAXL + 1);

  stage_t        stage, stage_d;
  logic          restart, clear, tick_sel, t_done, rel_q;
  logic          warm_any, warm_go;
  logic [CW-1:0] limit;
  logic [2:0]    cfg_norm, act_norm_unused;
  logic          act_ost, act_pll, cfg_ost_unused, cfg_pll_unused;

  rsq_mode_decode u_cfg_dec (
    .code(cfg_osc_mode), .norm(cfg_norm),
    .need_ost(cfg_ost_unused), .need_pll(cfg_pll_unused)
  );

  rsq_mode_decode u_act_dec (
    .code(active_osc), .norm(act_norm_unused),
    .need_ost(act_ost), .need_pll(act_pll)
  );

  assign warm_any = (|warm_req) | sw_reset;
  assign osc_en   = (stage == ST_OSCD) || (stage == ST_OST) ||
                    (stage == ST_LOCK) || (stage == ST_RUN);
  assign warm_go  = warm_any && osc_en && !por_low && !bor_low;

  always_comb begin
    unique case (stage)
      ST_PWRT: limit = CW'(PWRT_TICKS);
      ST_OSCD: limit = CW'(OSCD_TICKS);
      ST_OST:  limit = CW'(OST_CYCLES);
      ST_LOCK: limit = CW'(LOCK_TICKS);
      default: limit = CW'(1);
    endcase
  end

  assign tick_sel = (stage == ST_OST) ? osc_tick : ref_tick;

  rsq_delay_timer #(.CW(CW)) u_timer (
    .clk(clk), .arst_n(arst_n), .clear(clear),
    .tick(tick_sel), .limit(limit), .done(t_done)
  );

  always_comb begin
    stage_d = stage;
    restart = 1'b0;
    unique case (stage)
      ST_POR, ST_BOR: stage_d = ST_PWRT;
      ST_PWRT: if (t_done) stage_d = ST_OSCD;
      ST_OSCD: if (t_done) stage_d = act_ost ? ST_OST : (act_pll ? ST_LOCK : ST_RUN);
      ST_OST:  if (t_done) stage_d = act_pll ? ST_LOCK : ST_RUN;
      ST_LOCK: if (t_done) stage_d = ST_RUN;
      default: stage_d = stage;
    endcase
    if (warm_go) begin
      stage_d = ST_OSCD;
      restart = 1'b1;
    end
    if (bor_low) stage_d = ST_BOR;
    if (por_low) stage_d = ST_POR;
  end

  assign clear = restart || (stage_d != stage);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage      <= ST_POR;
      active_osc <= 3'd0;
      rst_cause  <= CAUSE_POR;
      rel_q      <= 1'b0;
    end else begin
      stage <= stage_d;
      rel_q <= (stage == ST_RUN);
      if (stage == ST_POR || stage == ST_BOR) active_osc <= cfg_norm;
      if (por_low)      rst_cause <= CAUSE_POR;
      else if (bor_low) rst_cause <= CAUSE_BOR;
      else if (warm_go) rst_cause <= CAUSE_WARM;
    end
  end

  assign sys_rst    = (stage != ST_RUN);
  assign clkmon_en  = (stage == ST_RUN);
  assign boot_fetch = (stage == ST_RUN) && !rel_q;
  assign fetch_addr = boot_fetch ? RESET_VEC : '0;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
  import rsq_pkg::*;
(
  input logic       clk,
  input logic       arst_n,
  input logic       por_low,
  input logic       bor_low,
  input logic       sys_rst,
  input logic       osc_en,
  input logic       boot_fetch,
  input logic       warm_go,
  input stage_t     stage,
  input logic [2:0] active_osc,
  input logic [1:0] rst_cause
);
  AST_POR_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    por_low |=> (sys_rst && rst_cause == CAUSE_POR)); // R1
  AST_BOR_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
    (bor_low && !por_low) |=> (sys_rst && rst_cause == CAUSE_BOR)); // R2
  AST_WARM_KEEP_OSC: assert property (@(posedge clk) disable iff (!arst_n)
    warm_go |=> $stable(active_osc)); // R4
  AST_OSC_AFTER_PWRT: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(osc_en) |-> $past(stage) == ST_PWRT); // R5
  AST_PLL_LAST: assert property (@(posedge clk) disable iff (!arst_n)
    ($fell(sys_rst) && osc_has_pll(active_osc)) |-> $past(stage) == ST_LOCK); // R6
  AST_WARM_RESTART: assert property (@(posedge clk) disable iff (!arst_n)
    warm_go |=> stage == ST_OSCD); // R8
  AST_RELEASE_FETCH: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(sys_rst) |-> boot_fetch); // R9
  AST_FETCH_ONCE: assert property (@(posedge clk) disable iff (!arst_n)
    boot_fetch |=> !boot_fetch); // R9
endmodule

bind rsq_top rsq_checker u_chk (
  .clk(clk), .arst_n(arst_n), .por_low(por_low), .bor_low(bor_low),
  .sys_rst(sys_rst), .osc_en(osc_en), .boot_fetch(boot_fetch),
  .warm_go(warm_go), .stage(stage), .active_osc(active_osc),
  .rst_cause(rst_cause)
);

// File: tb/tb_rsq_top.sv
module tb_rsq_top;
  localparam int NW = 3, AW = 24, P = 5, D = 3, OSTC = 1024, L = 7;

  logic clk = 1'b0, arst_n = 1'b0, por_low = 1'b0, bor_low = 1'b0;
  logic [NW-1:0] warm_req = '0;
  logic sw_reset = 1'b0, ref_tick = 1'b1, osc_tick = 1'b1;
  logic [2:0] cfg_osc_mode = 3'd0;
  logic sys_rst, osc_en, clkmon_en, boot_fetch;
  logic [AW-1:0] fetch_addr;
  logic [2:0] active_osc;
  logic [1:0] rst_cause;
  int total = 0, bad = 0, n = 0;

  always #5 clk = ~clk;

  rsq_top #(.NWARM(NW), .AW(AW), .PWRT_TICKS(P), .OSCD_TICKS(D),
            .OST_CYCLES(OSTC), .LOCK_TICKS(L)) dut (
    .clk(clk), .arst_n(arst_n), .por_low(por_low), .bor_low(bor_low),
    .warm_req(warm_req), .sw_reset(sw_reset), .ref_tick(ref_tick),
    .osc_tick(osc_tick), .cfg_osc_mode(cfg_osc_mode), .sys_rst(sys_rst),
    .osc_en(osc_en), .clkmon_en(clkmon_en), .boot_fetch(boot_fetch),
    .fetch_addr(fetch_addr), .active_osc(active_osc), .rst_cause(rst_cause));

  function automatic int norm_m(input int m);
    return (m == 4 || m == 6) ? 0 : m;
  endfunction
  function automatic int osc_len(input int m);
    int k = norm_m(m);
    return D + ((k == 2 || k == 3) ? OSTC : 0) + ((k == 1 || k == 3) ? L : 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); n++; @(negedge clk);
  endtask

  task automatic to_release();
    while (sys_rst && n < 4000) edge1();
  endtask

  task automatic release_checks(input string tag);
    chk({tag, " R9 boot_fetch"}, int'(boot_fetch), 1);
    chk({tag, " R9 fetch_addr"}, int'(fetch_addr), 0);
    chk({tag, " R9 clkmon_en"}, int'(clkmon_en), 1);
    edge1();
    chk({tag, " R9 strobe one cycle"}, int'(boot_fetch), 0);
  endtask

  task automatic cold(input bit use_por, input bit both);
    por_low = use_por | both; bor_low = ~use_por | both;
    repeat (3) @(negedge clk);
    por_low = 1'b0; bor_low = 1'b0; n = 0;
    edge1();
    chk("R5 osc_en low in power-up timer", int'(osc_en), 0);
    to_release();
  endtask

  task automatic warm(input int src);
    if (src < 0) sw_reset = 1'b1; else warm_req[src] = 1'b1;
    n = 0; edge1();
    sw_reset = 1'b0; warm_req = '0;
    to_release();
  endtask

  initial begin
    #10000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sys_rst", int'(sys_rst), 1);
    chk("R5 reset osc_en", int'(osc_en), 0);
    chk("R9 reset clkmon_en", int'(clkmon_en), 0);
    chk("R1 reset cause", int'(rst_cause), 1);
    arst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      int m2 = (m + 3) % 8;
      cfg_osc_mode = 3'(m);
      cold(1'b1, 1'b0);
      chk("R6 cold length", n, 1 + P + osc_len(m));
      chk("R3 cold reload", int'(active_osc), norm_m(m));
      chk("R1 cause power-on", int'(rst_cause), 1);
      release_checks("cold");
      cfg_osc_mode = 3'(m2);
      warm((m % 2 == 1) ? (m % NW) : -1);
      chk("R7 warm length", n, 1 + osc_len(m));
      chk("R4 warm keeps osc", int'(active_osc), norm_m(m));
      chk("R4 cause warm", int'(rst_cause), 3);
      release_checks("warm");
      cold(1'b0, 1'b0);
      chk("R2 brown-out length", n, 1 + P + osc_len(m2));
      chk("R3 reload after brown-out", int'(active_osc), norm_m(m2));
      chk("R2 cause brown-out", int'(rst_cause), 2);
    end

    cfg_osc_mode = 3'd5;
    cold(1'b1, 1'b1);
    chk("R1 power-on precedence", int'(rst_cause), 1);
    chk("R1 length both detectors", n, 1 + P + D);

    cfg_osc_mode = 3'd0;
    por_low = 1'b1; repeat (2) @(negedge clk); por_low = 1'b0; n = 0;
    edge1(); edge1();
    sw_reset = 1'b1; edge1(); sw_reset = 1'b0;
    to_release();
    chk("R8 warm in power-up timer ignored", n, 1 + P + D);
    chk("R8 cause unchanged", int'(rst_cause), 1);

    cfg_osc_mode = 3'd2;
    cold(1'b1, 1'b0);
    warm_req[0] = 1'b1; n = 0; edge1(); warm_req = '0;
    repeat (50) edge1();
    chk("R8 inside start-up timer", int'(sys_rst), 1);
    sw_reset = 1'b1; n = 0; edge1(); sw_reset = 1'b0;
    to_release();
    chk("R8 restart in start-up timer", n, 1 + D + OSTC);
    chk("R8 restart cause", int'(rst_cause), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule